// File: doc/BRIEF.md
# Byte-wide SPI master port

This block is a single-byte SPI master that sits on a small 8-bit register bus. Software chooses the clock phase, idle clock polarity, bit order and an optional internal loopback through a mode register, sets the SCK rate through a divisor register, places a byte in the transmit register and writes the start bit. The port then runs exactly eight SCK pulses, sending the byte on MOSI and collecting eight bits from MISO in the same pass. At the end it stores the collected byte, raises a receive-ready flag and drives its interrupt line high.

Because sending and receiving are one action, reading a byte from a slave means transmitting a dummy byte. Chip select is not part of the port; it comes from a separate general-purpose output. The register bus is never stalled: reads are combinational and writes take effect on the next clock edge.

Top module: `spi_byte_port`

## Requirements
- R1: After synchronous reset, all registers read 0x00, `irq` is low, `sck` is low and `mosi` is low.
- R2: Register offsets are mode 0x0 (bits 4..0 kept, upper bits read 0), received byte 0x1, transmit byte 0x2, control 0x3, status 0x4, divisor 0x6. The transmit byte, divisor and mode read back what was written; control, 0x5 and 0x7 read 0x00; writes to offset 0x1 are ignored.
- R3: A write to offset 0x3 with bit 0 set, while mode bit 0x08 (enable) is 1 and no transfer runs, starts a transfer; status bit 1 reads 1 from the next cycle for exactly 16 x (divisor + 1) cycles.
- R4: During a transfer SCK has a half-period of divisor + 1 cycles, starts at its idle level and makes eight full pulses; a divisor of 0x18 gives a 400-cycle transfer.
- R5: With mode bit 0x04 set, bit 7 is sent first and the first received bit lands in bit 7; with it clear, bit 0 goes first in both directions.
- R6: With mode bit 0x10 clear, MOSI holds the first bit from the start, MISO is captured on each leading SCK edge and MOSI changes on trailing edges; with it set, MOSI changes on the leading edges after the first one and MISO is captured on trailing edges.
- R7: At the end of a transfer the received byte appears at offset 0x1, status bit 0 and `irq` go high; a read of offset 0x1 clears both, except in the cycle a transfer ends, where setting wins.
- R8: With mode bit 0x01 set, the received byte is the bitwise inverse of the transmitted byte and MISO has no effect.
- R9: A start request during a transfer is ignored, and a write to the transmit register during a transfer does not change the byte being sent.
- R10: Mode bit 0x02 makes SCK idle high; with the enable bit clear SCK stays at its idle level, MOSI is low and start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears ready on offset 0x1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| irq | output | 1 | High while a received byte waits to be read |

## Verification
The bench checks every SCK and MOSI level against a timing model, so an off-by-one in the divisor count would stretch or shrink each half-period and a phase mix-up would move MOSI changes onto the wrong edge. It drives MISO from a slave byte in step with the model, so a reversed bit order or a capture on the wrong edge returns a shifted or mirrored byte. It times a read of the received byte into the very cycle a transfer ends; a design that let the clear win would lose the ready flag and interrupt. It also retries the start bit mid-transfer and with the port disabled, where a design that honoured it would restart the shift pattern or toggle SCK.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int STEPS   = 2 * BYTE_W;
    localparam int STEP_W  = $clog2(STEPS);

    localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 3'd6;

    // field order matches the bit positions software uses (bit 4 down to bit 0)
    typedef struct packed {
        logic cpha;
        logic enable;
        logic msb_first;
        logic cpol;
        logic loopback;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef logic [BYTE_W-1:0] byte_t;

    function automatic logic head_bit(input byte_t d, input logic msb);
        return msb ? d[BYTE_W-1] : d[0];
    endfunction

    function automatic byte_t drop_head(input byte_t d, input logic msb);
        return msb ? {d[BYTE_W-2:0], 1'b0} : {1'b0, d[BYTE_W-1:1]};
    endfunction

    function automatic byte_t push_bit(input byte_t d, input logic b, input logic msb);
        return msb ? {d[BYTE_W-2:0], b} : {b, d[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  byte_t             wdata,
    output byte_t             rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  byte_t             rx_i,
    output mode_t             mode_o,
    output byte_t             div_o,
    output byte_t             tx_o,
    output logic              start_o,
    output logic              ready_o
);
    mode_t mode_q;
    byte_t div_q, tx_q, rx_q;
    logic  ready_q;

    logic  rx_read;
    assign rx_read = rd && (addr == OFF_RXD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            div_q  <= '0;
            tx_q   <= '0;
        end else if (wr) begin
            case (addr)
                OFF_MODE: mode_q <= mode_t'(wdata[MODE_W-1:0]);
                OFF_TXD:  tx_q   <= wdata;
                OFF_DIV:  div_q  <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q    <= '0;
            ready_q <= 1'b0;
        end else if (done_i) begin
            rx_q    <= rx_i;
            ready_q <= 1'b1;
        end else if (rx_read) begin
            ready_q <= 1'b0;
        end
    end

    assign start_o = wr && (addr == OFF_CTRL) && wdata[0] && mode_q.enable && !busy_i;

    always_comb begin
        case (addr)
            OFF_MODE: rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
            OFF_RXD:  rdata = rx_q;
            OFF_TXD:  rdata = tx_q;
            OFF_STAT: rdata = {{(BYTE_W-2){1'b0}}, busy_i, ready_q};
            OFF_DIV:  rdata = div_q;
            default:  rdata = '0;
        endcase
    end

    assign mode_o  = mode_q;
    assign div_o   = div_q;
    assign tx_o    = tx_q;
    assign ready_o = ready_q;

    // R7: a finished transfer always leaves the ready flag set
    a_r7_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done_i |=> ready_q);

    // R7: reading the received byte clears the flag when no transfer ends
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rx_read && !done_i) |=> !ready_q);

    // R2: writes to the received-byte offset leave it untouched
    a_r2_rx_readonly: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFF_RXD && !done_i) |=> $stable(rx_q));

endmodule

// File: rtl/spi_byte_timer.sv
module spi_byte_timer
    import spi_byte_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    input  logic  start_i,
    input  byte_t div_i,
    output logic  tick_o
);
    byte_t cnt_q;
    logic  wrap;

    assign wrap   = (cnt_q == div_i);
    assign tick_o = run_i && wrap;

    always_ff @(posedge clk) begin
        if (rst || start_i || !run_i || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4: the half-period counter never passes the divisor during a transfer
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (run_i && $stable(div_i)) |-> (cnt_q <= div_i));

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
    import spi_byte_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  tick_i,
    input  mode_t mode_i,
    input  byte_t tx_i,
    input  logic  miso_i,
    output logic  busy_o,
    output logic  sck_lvl_o,
    output logic  mosi_bit_o,
    output logic  done_o,
    output byte_t rx_o
);
    logic              busy_q, lvl_q;
    logic [STEP_W-1:0] step_q;
    byte_t             tx_sh, rx_sh, rx_next;
    logic              lead, trail, capture, advance, in_bit, last;

    assign last       = (step_q == STEP_W'(STEPS-1));
    assign lead       = busy_q && tick_i && !step_q[0];
    assign trail      = busy_q && tick_i &&  step_q[0];
    assign capture    = mode_i.cpha ? trail : lead;
    assign advance    = mode_i.cpha ? (lead && step_q != '0) : (trail && !last);
    assign mosi_bit_o = head_bit(tx_sh, mode_i.msb_first);
    assign in_bit     = mode_i.loopback ? ~mosi_bit_o : miso_i;
    assign rx_next    = capture ? push_bit(rx_sh, in_bit, mode_i.msb_first) : rx_sh;
    assign done_o     = busy_q && tick_i && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            lvl_q  <= 1'b0;
            step_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            lvl_q  <= 1'b0;
            step_q <= '0;
            tx_sh  <= tx_i;
            rx_sh  <= '0;
        end else if (busy_q && tick_i) begin
            lvl_q  <= ~lvl_q;
            step_q <= step_q + 1'b1;
            rx_sh  <= rx_next;
            if (advance)
                tx_sh <= drop_head(tx_sh, mode_i.msb_first);
            if (last)
                busy_q <= 1'b0;
        end
    end

    assign busy_o    = busy_q;
    assign sck_lvl_o = lvl_q;
    assign rx_o      = rx_next;

    // R3: a transfer only begins after a start request
    a_r3_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(start_i));

    // R9: a running transfer is not cut short or restarted
    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_o) |=> (busy_q && (step_q == $past(step_q) || step_q == $past(step_q) + 1'b1)));

    // R3: the final SCK step ends the transfer
    a_r3_done_ends: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_q);

    // R4: the SCK step moves only on a timer tick
    a_r4_step_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick_i) |=> $stable(step_q) && $stable(lvl_q));

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sck,
    output logic       mosi,
    input  logic       miso,
    output logic       irq
);
    mode_t mode;
    byte_t div, tx, rx;
    logic  start, busy, done, tick, lvl, out_bit, ready;

    spi_byte_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .busy_i  (busy),
        .done_i  (done),
        .rx_i    (rx),
        .mode_o  (mode),
        .div_o   (div),
        .tx_o    (tx),
        .start_o (start),
        .ready_o (ready)
    );

    spi_byte_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .run_i   (busy),
        .start_i (start),
        .div_i   (div),
        .tick_o  (tick)
    );

    spi_byte_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .tick_i     (tick),
        .mode_i     (mode),
        .tx_i       (tx),
        .miso_i     (miso),
        .busy_o     (busy),
        .sck_lvl_o  (lvl),
        .mosi_bit_o (out_bit),
        .done_o     (done),
        .rx_o       (rx)
    );

    assign sck  = mode.enable ? (lvl ^ mode.cpol) : mode.cpol;
    assign mosi = mode.enable && busy && out_bit;
    assign irq  = ready;

    // R10: between transfers SCK rests at its idle level
    a_r10_idle_sck: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == mode.cpol));

    // R10: between transfers MOSI is low
    a_r10_idle_mosi: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mosi);

endmodule

// File: tb/sim_spi_byte_port.sv
`timescale 1ns/1ps
module sim_spi_byte_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck, mosi, irq;
    logic       miso = 1'b0;

    always #5 clk = ~clk;

    spi_byte_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    // ---------------- behavioural reference model ----------------
    logic [4:0] m_mode = '0;
    logic [7:0] m_div = '0, m_tx = '0, m_rx = '0, m_exp = '0, m_ltx = '0;
    logic [7:0] sl_byte = '0;
    bit         m_busy = 0, m_rdy = 0;
    int         m_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = '0; m_div = '0; m_tx = '0; m_rx = '0;
            m_busy = 0; m_rdy = 0; m_n = 0;
        end else begin
            bit st;
            st = bus_wr && bus_addr == 3'd3 && bus_wdata[0] && m_mode[3] && !m_busy;
            if (bus_rd && bus_addr == 3'd1) m_rdy = 0;
            if (m_busy) begin
                m_n++;
                if (m_n == 16 * (int'(m_div) + 1)) begin
                    m_busy = 0; m_rdy = 1; m_rx = m_exp;
                end
            end
            if (st) begin
                m_busy = 1; m_n = 0; m_ltx = m_tx;
                m_exp = m_mode[0] ? ~m_tx : sl_byte;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_mode = bus_wdata[4:0];
                    3'd2: m_tx   = bus_wdata;
                    3'd6: m_div  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic int cur_idx();
        int h;
        h = m_n / (int'(m_div) + 1);
        if (m_mode[4]) return (h == 0) ? 0 : (h - 1) / 2;
        return h / 2;
    endfunction

    // drive MISO and compare pins away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int idx, h;
            logic exp_sck, exp_mosi, lvl;
            idx = cur_idx();
            h   = m_n / (int'(m_div) + 1);
            lvl = m_busy ? h[0] : 1'b0;
            exp_sck  = m_mode[3] ? (lvl ^ m_mode[1]) : m_mode[1];
            exp_mosi = (m_mode[3] && m_busy) ?
                       (m_mode[2] ? m_ltx[7-idx] : m_ltx[idx]) : 1'b0;
            checks++;
            if (sck !== exp_sck) begin
                failures++;
                $display("FAIL R4 sck at n=%0d: got %b expected %b", m_n, sck, exp_sck);
            end
            if (mosi !== exp_mosi) begin
                failures++;
                $display("FAIL R6 mosi at n=%0d: got %b expected %b", m_n, mosi, exp_mosi);
            end
            if (irq !== m_rdy) begin
                failures++;
                $display("FAIL R7 irq: got %b expected %b", irq, m_rdy);
            end
            miso = m_busy ? (m_mode[2] ? sl_byte[7-idx] : sl_byte[idx]) : 1'b0;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s read off %0d: got %h expected %h", tag, a, bus_rdata, exp);
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic xfer(input logic [7:0] mode, input logic [7:0] dv, input logic [7:0] txb,
                        input logic [7:0] slb, input string tag);
        wr(3'd0, mode);
        wr(3'd6, dv);
        wr(3'd2, txb);
        sl_byte = slb;
        wr(3'd3, 8'h01);
        wait_idle();
        rd_chk(3'd4, 8'h01, tag);
        rd_chk(3'd1, mode[0] ? ~txb : slb, tag);
        rd_chk(3'd4, 8'h00, "R7 ready cleared");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        done_flag = 1;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(irq === 1'b0 && sck === 1'b0 && mosi === 1'b0, "R1 pins", {irq, sck, mosi}, 0);
        rd_chk(3'd0, 8'h00, "R1 mode");
        rd_chk(3'd4, 8'h00, "R1 status");
        rd_chk(3'd6, 8'h00, "R1 divisor");
        rd_chk(3'd1, 8'h00, "R1 rx");

        // R2 register map
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'h1F, "R2 mode width");
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hC3);
        rd_chk(3'd2, 8'hC3, "R2 tx");
        wr(3'd6, 8'h07);
        rd_chk(3'd6, 8'h07, "R2 div");
        rd_chk(3'd3, 8'h00, "R2 ctrl");
        rd_chk(3'd5, 8'h00, "R2 gap5");
        rd_chk(3'd7, 8'h00, "R2 gap7");

        // R3 R5 R6 msb first, phase 0
        xfer(8'h0C, 8'h01, 8'hA5, 8'h3C, "R5 msb first phase0");
        // R5 R6 lsb first, phase 1, inverted clock (R10)
        xfer(8'h1A, 8'h02, 8'h81, 8'h6E, "R6 lsb first phase1 cpol");
        // R6 msb first, phase 1, div 0
        xfer(8'h1C, 8'h00, 8'h4B, 8'hD2, "R6 msb phase1 div0");
        // R8 loopback, miso carries junk
        xfer(8'h0D, 8'h01, 8'h5A, 8'h5A, "R8 loopback");

        // R2 rx offset is read-only
        wr(3'd1, 8'h00);
        rd_chk(3'd1, 8'hA5, "R2 rx write ignored");

        // R9 start and tx write during a transfer
        wr(3'd0, 8'h0C);
        wr(3'd6, 8'h01);
        wr(3'd2, 8'h96);
        sl_byte = 8'h17;
        wr(3'd3, 8'h01);
        repeat (5) @(negedge clk);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h01);
        rd_chk(3'd4, 8'h02, "R3 busy during transfer");
        wait_idle();
        rd_chk(3'd1, 8'h17, "R9 rx after ignored start");
        rd_chk(3'd4, 8'h00, "R9 no second transfer");

        // R4 divisor 0x18 gives 400-cycle transfer
        begin
            int cnt;
            wr(3'd6, 8'h18);
            wr(3'd2, 8'h3E);
            sl_byte = 8'hE1;
            wr(3'd3, 8'h01);
            cnt = 0;
            while (!irq && cnt < 1000) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == 400, "R4 transfer length", cnt, 400);
            rd_chk(3'd1, 8'hE1, "R4 rx");
        end

        // R7 read of rx in the cycle the transfer ends: set wins
        wr(3'd6, 8'h00);
        wr(3'd2, 8'h29);
        sl_byte = 8'hB4;
        wr(3'd3, 8'h01);
        while (!(m_busy && m_n == 15)) @(negedge clk);
        bus_addr = 3'd1; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(irq === 1'b1, "R7 set wins over clear", irq, 1);
        rd_chk(3'd1, 8'hB4, "R7 rx after collision");
        chk(irq === 1'b0, "R7 irq cleared by read", irq, 0);

        // R10 disabled port ignores start, idle high clock
        wr(3'd0, 8'h02);
        wr(3'd3, 8'h01);
        repeat (3) @(negedge clk);
        chk(sck === 1'b1 && mosi === 1'b0, "R10 disabled pins", {sck, mosi}, 2);
        rd_chk(3'd4, 8'h00, "R10 start ignored");

        done_flag = 1;
        summary();
        $finish;
    end

endmodule